// File: doc/BRIEF.md
# Synchronized Two-Port Sample Demultiplexer

This block accepts a free-running stream of converter samples, one on every rising clock edge, and splits it across two half-rate output ports, A and B. A sync input, synchronized on chip, lets an external timing event decide which sample lands on port A. Several instances driven from one shared sync line therefore keep the same port phasing. While the sync input is high, every output is frozen.

Two output modes are offered. In interleaved mode each sample reaches its port a fixed 14 cycles after capture, so the two ports update on alternate cycles. In dual-parallel mode port A carries one extra cycle of delay, so a sample pair leaves on both ports together. A half-rate data-ready clock marks when the port data is stable. A data-valid flag goes high once fresh samples from the current alignment reach the ports.

The sample stream has no back-pressure. The converter cannot be stalled, so there is no ready signal, and a sample is taken on every clock edge. Downstream logic must accept each port update as it appears, and it uses `data_ok` to tell fresh data from stale data. The sync path is the only control; it has no handshake.

Top module: `pair_demux`

## Requirements
- R1: While `rst_n` is low, `port_a`, `port_b`, `dr_clk` and `data_ok` are all 0.
- R2: `sync_hold` passes through a two-flop synchronizer. From the second rising edge after the pin rises until realignment, `port_a`, `port_b` and `dr_clk` do not change.
- R3: The synchronized falling edge of `sync_hold` marks capture edge N, which is the third rising edge after the pin falls. The sample captured at N is routed to port A, the one at N+1 to port B, and later samples alternate A, B, A, B.
- R4: With `dual_mode` = 0 (interleaved), every sample appears on its port at the 14th rising edge after the edge that captured it, so the two ports update on alternate cycles.
- R5: With `dual_mode` = 1 (dual-parallel), port A has 15 cycles of latency and port B has 14, so samples N+2k and N+2k+1 appear on A and B at the same edge.
- R6: With `lvds_sel` = 1, `sync_hold` is ignored and treated as permanently low: the stream and its port phasing continue through any pulse on it. `lvds_sel` = 0 selects the CMOS-style mode in which sync is honoured.
- R7: `dr_clk` changes only on edges where a sample leaves the delay chain. In interleaved mode it goes 0 with a port A update and 1 with a port B update. In dual-parallel mode it goes 0 with each pair update and 1 one cycle later.
- R8: `data_ok` goes to 0 on the edge where the synchronized hold is first seen. It goes to 1 on the edge where port A first receives a sample captured after the latest alignment.
- R9: Reset acts as an asserted sync. If `sync_hold` is low (or ignored) when reset is released, edge N is the third rising edge after the release.
- R10: Samples captured in the two cycles before a hold takes effect are discarded. They never appear on a port, even if the hold is shorter than the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dual_mode | input | 1 | 0 = interleaved, 1 = dual-parallel |
| lvds_sel | input | 1 | 1 = sync ignored, 0 = sync honoured |
| sync_hold | input | 1 | Asynchronous sync; high freezes outputs, fall aligns |
| smp_in | input | W | Converter sample captured on each rising edge |
| port_a | output | W | Port A sample data |
| port_b | output | W | Port B sample data |
| dr_clk | output | 1 | Half-rate data-ready clock |
| data_ok | output | 1 | Ports carry samples from the current alignment |

## Verification
On every cycle, the assertions check that the ports and `dr_clk` stay frozen under a synchronized hold, that `data_ok` clears during a hold, and that nothing on the output moves without a sample leaving the chain. They also check that port B updates only after a port A sample in the right relation for each mode, and that sync is ignored when `lvds_sel` is set. The exact edge N, the 14- and 15-cycle latencies, which sample lands on which port, and the discard of in-flight samples around a short hold need known data, so only the bench's scenarios can show them. The bench predicts each port and flag update from the sync timing it drives.

// File: rtl/pdx_pkg.sv
package pdx_pkg;
  typedef enum logic {
    PORT_A = 1'b0,
    PORT_B = 1'b1
  } port_e;
endpackage

// File: rtl/pdx_sync_edge.sv
// Synchronizes the sync pin and finds its falling edge.
module pdx_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_raw,
  input  logic lvds_sel,
  output logic held,
  output logic fall
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sr;
  logic         last;
  logic         gated;

  // In LVDS mode the pin is treated as permanently low.
  assign gated = sync_raw & ~lvds_sel;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '1;
        else        sr <= gated;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '1;
        else        sr <= {sr[TOP-1:0], gated};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= 1'b1;
    else        last <= sr[TOP];
  end

  assign held = sr[TOP];
  assign fall = last & ~sr[TOP];
endmodule

// File: rtl/pdx_phase_chain.sv
// Tags each sample with its port and delays it by LAT cycles.
module pdx_phase_chain
  import pdx_pkg::*;
#(
  parameter int W   = 12,
  parameter int LAT = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] smp,
  input  logic         held,
  input  logic         fall,
  output logic [W-1:0] tail_d,
  output port_e        tail_tag,
  output logic         tail_vld
);
  port_e phase;
  port_e tag_now;

  // The sync edge forces the current capture onto port A.
  assign tag_now = fall ? PORT_A : phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PORT_A;
    else        phase <= port_e'(~tag_now);
  end

  for (genvar i = 0; i < LAT; i++) begin : g_stg
    logic [W-1:0] d;
    port_e        t;
    logic         v;
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          d <= '0;
          t <= PORT_A;
          v <= 1'b0;
        end else begin
          d <= smp;
          t <= tag_now;
          v <= ~held;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          d <= '0;
          t <= PORT_A;
          v <= 1'b0;
        end else begin
          d <= g_stg[i-1].d;
          t <= g_stg[i-1].t;
          // A hold flushes every sample still in flight.
          v <= held ? 1'b0 : g_stg[i-1].v;
        end
      end
    end
  end

  assign tail_d   = g_stg[LAT-1].d;
  assign tail_tag = g_stg[LAT-1].t;
  assign tail_vld = g_stg[LAT-1].v;
endmodule

// File: rtl/pdx_port_stage.sv
// Output registers, dual-mode pairing register, data-ready clock and valid flag.
module pdx_port_stage
  import pdx_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dual_mode,
  input  logic         held,
  input  logic [W-1:0] tail_d,
  input  port_e        tail_tag,
  input  logic         tail_vld,
  output logic [W-1:0] port_a,
  output logic [W-1:0] port_b,
  output logic         dr_clk,
  output logic         data_ok,
  output logic         upd_a,
  output logic         upd_b,
  output logic         tick
);
  logic         is_a;
  logic [W-1:0] a_hold;

  assign tick  = tail_vld & ~held;
  assign is_a  = (tail_tag == PORT_A);
  assign upd_a = tick & (dual_mode ? ~is_a : is_a);
  assign upd_b = tick & ~is_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_hold <= '0;
      port_a <= '0;
      port_b <= '0;
      dr_clk <= 1'b0;
    end else begin
      if (tick && is_a) a_hold <= tail_d;
      if (upd_a)        port_a <= dual_mode ? a_hold : tail_d;
      if (upd_b)        port_b <= tail_d;
      if (tick)         dr_clk <= dual_mode ? is_a : ~is_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_ok <= 1'b0;
    else if (held)  data_ok <= 1'b0;
    else if (upd_a) data_ok <= 1'b1;
  end
endmodule

// File: rtl/pair_demux.sv
module pair_demux
  import pdx_pkg::*;
#(
  parameter int W           = 12,
  parameter int LAT         = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dual_mode,
  input  logic         lvds_sel,
  input  logic         sync_hold,
  input  logic [W-1:0] smp_in,
  output logic [W-1:0] port_a,
  output logic [W-1:0] port_b,
  output logic         dr_clk,
  output logic         data_ok
);
  logic         held;
  logic         fall;
  logic [W-1:0] tail_d;
  port_e        tail_tag;
  logic         tail_vld;
  logic         upd_a;
  logic         upd_b;
  logic         tick;

  pdx_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_raw (sync_hold),
    .lvds_sel (lvds_sel),
    .held     (held),
    .fall     (fall)
  );

  pdx_phase_chain #(.W(W), .LAT(LAT)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp      (smp_in),
    .held     (held),
    .fall     (fall),
    .tail_d   (tail_d),
    .tail_tag (tail_tag),
    .tail_vld (tail_vld)
  );

  pdx_port_stage #(.W(W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .dual_mode (dual_mode),
    .held      (held),
    .tail_d    (tail_d),
    .tail_tag  (tail_tag),
    .tail_vld  (tail_vld),
    .port_a    (port_a),
    .port_b    (port_b),
    .dr_clk    (dr_clk),
    .data_ok   (data_ok),
    .upd_a     (upd_a),
    .upd_b     (upd_b),
    .tick      (tick)
  );
endmodule

// File: rtl/pair_demux_chk.sv
module pair_demux_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         dual_mode,
  input logic         lvds_sel,
  input logic         held,
  input logic         tick,
  input logic         upd_a,
  input logic         upd_b,
  input logic [W-1:0] port_a,
  input logic [W-1:0] port_b,
  input logic         dr_clk,
  input logic         data_ok
);
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> $stable(port_a) && $stable(port_b) && $stable(dr_clk));

  assert_il_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual_mode && upd_b) |-> $past(upd_a));

  assert_dual_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_mode && upd_b) |-> $past(tick && !upd_b));

  assert_lvds_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && lvds_sel && $past(lvds_sel) && $past(lvds_sel, 2)) |-> !held);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(dr_clk) && $stable(port_a) && $stable(port_b));

  assert_ok_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> !data_ok);
endmodule

bind pair_demux pair_demux_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dual_mode (dual_mode),
  .lvds_sel  (lvds_sel),
  .held      (held),
  .tick      (tick),
  .upd_a     (upd_a),
  .upd_b     (upd_b),
  .port_a    (port_a),
  .port_b    (port_b),
  .dr_clk    (dr_clk),
  .data_ok   (data_ok)
);

// File: tb/test_pair_demux.sv
module test_pair_demux;
  localparam int  W          = 12;
  localparam int  LAT        = 14;
  localparam time CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         dual_mode = 1'b0;
  logic         lvds_sel = 1'b0;
  logic         sync_hold = 1'b1;
  logic [W-1:0] smp_in = '0;
  logic [W-1:0] port_a;
  logic [W-1:0] port_b;
  logic         dr_clk;
  logic         data_ok;

  pair_demux #(.W(W), .LAT(LAT)) i_pair_demux (
    .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode), .lvds_sel(lvds_sel),
    .sync_hold(sync_hold), .smp_in(smp_in), .port_a(port_a), .port_b(port_b),
    .dr_clk(dr_clk), .data_ok(data_ok)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int           at;
    int           kind;  // 0 port A, 1 port B, 2 dr_clk, 3 data_ok clear
    logic [W-1:0] val;
  } item_t;

  item_t        exp_q[$];
  int           n_run = 0;
  int           n_fail = 0;
  logic [W-1:0] ea = '0;
  logic [W-1:0] eb = '0;
  logic         edr = 1'b0;
  logic         edok = 1'b0;
  bit           armed = 0;
  bit           hold_req = 1;
  bit           done = 0;
  int           n_align = 0;
  logic [W-1:0] seq = 12'd100;
  string        tag = "R1";

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Monitor: applies due expectations, then compares all outputs.
  always @(negedge clk) begin
    item_t it;
    if (rst_n) begin
      while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
        it = exp_q.pop_front();
        case (it.kind)
          0: begin ea = it.val; edok = 1'b1; end
          1: eb = it.val;
          2: edr = it.val[0];
          default: edok = 1'b0;
        endcase
      end
      chk(port_a == ea,   {tag, " R3"}, "port_a",  int'(port_a),  int'(ea));
      chk(port_b == eb,   {tag, " R3"}, "port_b",  int'(port_b),  int'(eb));
      chk(dr_clk == edr,  {tag, " R7"}, "dr_clk",  int'(dr_clk),  int'(edr));
      chk(data_ok == edok, {tag, " R8"}, "data_ok", int'(data_ok), int'(edok));
    end
  end

  task automatic push_exp(int c, logic [W-1:0] v);
    int k;
    bit is_a;
    logic [W-1:0] dr;
    k    = c - n_align;
    is_a = (k % 2) == 0;
    dr   = dual_mode ? W'(is_a) : W'(!is_a);
    if (dual_mode) begin
      if (is_a) begin
        exp_q.push_back('{c + LAT, 2, dr});
        exp_q.push_back('{c + LAT + 1, 0, v});
      end else begin
        exp_q.push_back('{c + LAT, 1, v});
        exp_q.push_back('{c + LAT, 2, dr});
      end
    end else begin
      exp_q.push_back('{c + LAT, is_a ? 0 : 1, v});
      exp_q.push_back('{c + LAT, 2, dr});
    end
  endtask

  // Driver: one sample per cycle, plus any pending sync pin change.
  task automatic step();
    int c;
    @(negedge clk);
    if (sync_hold != hold_req) begin
      sync_hold = hold_req;
      if (!lvds_sel) begin
        if (hold_req) begin
          // R10: in-flight samples are dropped; last port update at E1.
          armed = 0;
          while (exp_q.size() > 0 && exp_q[exp_q.size()-1].at > cyc + 2)
            exp_q.delete(exp_q.size() - 1);
          exp_q.push_back('{cyc + 3, 3, '0});
        end else begin
          armed   = 1;
          n_align = cyc + 3;
        end
      end
    end
    smp_in = seq;
    c = cyc + 1;
    if (armed && c >= n_align) push_exp(c, seq);
    seq = seq + 1'b1;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_reset(bit d, bit l, bit h);
    @(negedge clk);
    rst_n = 1'b0;
    dual_mode = d; lvds_sel = l; sync_hold = h; hold_req = h;
    exp_q.delete();
    ea = '0; eb = '0; edr = 1'b0; edok = 1'b0; armed = 0;
    repeat (3) @(negedge clk);
    chk(port_a == '0, "R1", "reset port_a", int'(port_a), 0);
    chk(port_b == '0, "R1", "reset port_b", int'(port_b), 0);
    chk(dr_clk == 1'b0, "R1", "reset dr_clk", int'(dr_clk), 0);
    chk(data_ok == 1'b0, "R1", "reset data_ok", int'(data_ok), 0);
    rst_n = 1'b1;
    if (!(h && !l)) begin
      armed   = 1;          // R9: reset release acts as a sync fall
      n_align = cyc + 3;
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    // Interleaved: R3 R4 alignment and latency, then a short hold (R2 R10).
    tag = "R4";
    do_reset(1'b0, 1'b0, 1'b1);
    run(4);
    hold_req = 0; run(40);
    tag = "R2 R10";
    hold_req = 1; run(6);
    hold_req = 0; tag = "R4"; run(40);

    // Dual-parallel: R5 pairing, then a hold and realignment.
    tag = "R5";
    do_reset(1'b1, 1'b0, 1'b1);
    run(3);
    hold_req = 0; run(40);
    tag = "R2 R10";
    hold_req = 1; run(5);
    hold_req = 0; tag = "R5"; run(40);

    // Sync ignored in LVDS mode (R6); power-on alignment from reset (R9).
    tag = "R6 R9";
    do_reset(1'b0, 1'b1, 1'b0);
    run(20);
    hold_req = 1; run(6);
    hold_req = 0; run(30);

    run(5);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end
endmodule